// File: doc/BRIEF.md
# Windowed watchdog with escalation

This block supervises software liveness from a clock domain of its own. A down-counter is preset with a timeout value. Software must service it with a kick while the count lies inside an allowed window: the count must already have dropped to or below a configured open point, and must not yet have reached zero. A kick that comes too soon, or no kick at all, is a fault. A fault first raises a non-maskable interrupt request and starts a grace countdown. A kick during the grace countdown restores normal counting. If the grace time runs out instead, the block drives a reset line for a fixed number of cycles, records itself as the reset cause, and then restarts.

Kick, configuration, interrupt acknowledge, cause clear and disable requests originate on the bus clock. Each one reaches the watchdog clock as a toggle event through a two-flop synchronizer. The block can only be switched off by a two-write key sequence. A disable request is honoured only during normal counting, and the block stays off until its power-on reset.

FSM states: `ST_RUN` (counting the timeout), `ST_GRACE` (interrupt raised, counting the grace time), `ST_RESET` (reset line driven), `ST_OFF` (disabled). Transitions:
- `ST_RUN`→`ST_RUN`: a valid kick reloads the counter.
- `ST_RUN`→`ST_GRACE`: an early kick, or the count reaching zero.
- `ST_RUN`→`ST_OFF`: a completed unlock.
- `ST_GRACE`→`ST_RUN`: any kick.
- `ST_GRACE`→`ST_RESET`: the grace count reaching zero.
- `ST_RESET`→`ST_RUN`: the hold time has elapsed.

Top module: `wdw_watchdog`

## Requirements
- R1: After power-on reset, `nmi_req_o`=0, `wd_rst_o`=0, `active_o`=1 and `cause_o`=0, and the counter holds DEF_TIMEOUT.
- R2: In `ST_RUN` the counter decrements once per watchdog cycle. If it is found at zero with no kick, the block enters `ST_GRACE`.
- R3: A kick that arrives while the count is above the open point is an early fault and enters `ST_GRACE`. A kick that arrives at or below the open point reloads the timeout and raises no interrupt.
- R4: Entry to `ST_GRACE` sets `nmi_req_o`. The reset line is never high in the cycle in which `nmi_req_o` rises.
- R5: Any kick during `ST_GRACE` returns the block to `ST_RUN` with a reloaded counter, and the reset is not issued.
- R6: When the grace count expires, `wd_rst_o` is high for exactly RST_HOLD cycles (16 by default). The block then returns to `ST_RUN` enabled, with the timeout reloaded, and faults again if it is not kicked.
- R7: `cause_o` rises together with `wd_rst_o`. The block's own reset does not clear it. Only `cause_clr_i` or the power-on reset clears it.
- R8: `nmi_req_o` stays high, even after a recovering kick or a reset, until `nmi_ack_i` clears it.
- R9: A configuration write replaces timeout, open point and grace time. The timeout is used from the next reload, the open point from the next kick, and the grace time from the next fault.
- R10: A key write of KEY_FIRST (0xC35A) followed by a key write of KEY_SECOND (0x3CA5), with no other key write between them, moves the block to `ST_OFF`. There `active_o`=0, and neither the interrupt nor the reset is raised until the power-on reset. A different key value in between, or KEY_SECOND alone, has no effect.
- R11: A completed unlock that arrives in `ST_GRACE` or `ST_RESET` is ignored, and the escalation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| wd_clk | input | 1 | Watchdog counter clock |
| wd_rst_n | input | 1 | Watchdog power-on reset, active low |
| kick_i | input | 1 | Service kick, one bus cycle pulse |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_timeout_i | input | CNT_W | New timeout preset |
| cfg_open_i | input | CNT_W | New window open point (count value) |
| cfg_grace_i | input | CNT_W | New grace time |
| key_we_i | input | 1 | Key write strobe for the unlock sequence |
| key_data_i | input | KEY_W | Key value |
| nmi_ack_i | input | 1 | Interrupt acknowledge pulse |
| cause_clr_i | input | 1 | Reset-cause clear pulse |
| nmi_req_o | output | 1 | Latched non-maskable interrupt request |
| wd_rst_o | output | 1 | Hardware reset output |
| active_o | output | 1 | Watchdog enabled |
| cause_o | output | 1 | Watchdog was the source of the last reset |

## Verification
The bench builds the block with an 8-bit counter, a timeout of 40, an open point of 20, a grace time of 30 and the default 16-cycle reset hold. With these values a full escalation, from the last kick through the interrupt to the end of the reset pulse, takes under 100 watchdog cycles. The early, in-window and late kick regions are each several cycles wide, which is wider than the jitter of the clock-domain crossing. A reprogrammed timeout of 80 with a grace time of 10 moves both the fault and the reset by clearly measurable amounts.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_GRACE = 2'd1,
        ST_RESET = 2'd2,
        ST_OFF   = 2'd3
    } wd_state_e;

    // lane index of each bus-to-watchdog event
    localparam int EV_KICK = 0;
    localparam int EV_CFG  = 1;
    localparam int EV_DIS  = 2;
    localparam int EV_ACK  = 3;
    localparam int EV_CLR  = 4;
    localparam int EV_N    = 5;
endpackage

// File: rtl/wdw_pulse_xing.sv
// Toggle-based single-pulse crossing, one lane per event.
module wdw_pulse_xing #(
    parameter int N = 1
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [N-1:0] src_pulse,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [N-1:0] dst_pulse
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic       tog_q;
        logic [2:0] sync_q;

        always_ff @(posedge src_clk or negedge src_rst_n) begin
            if (!src_rst_n)        tog_q <= 1'b0;
            else if (src_pulse[i]) tog_q <= ~tog_q;
        end

        always_ff @(posedge dst_clk or negedge dst_rst_n) begin
            if (!dst_rst_n) sync_q <= '0;
            else            sync_q <= {sync_q[1:0], tog_q};
        end

        assign dst_pulse[i] = sync_q[2] ^ sync_q[1];
    end
endmodule

// File: rtl/wdw_unlock.sv
// Two-key disable sequencer in the bus domain.
module wdw_unlock #(
    parameter int              KEY_W      = 16,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hC35A,
    parameter logic [KEY_W-1:0] KEY_SECOND = 16'h3CA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_data,
    output logic             disable_pulse
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q       <= 1'b0;
            disable_pulse <= 1'b0;
        end else begin
            disable_pulse <= 1'b0;
            if (key_we) begin
                if (armed_q && key_data == KEY_SECOND) begin
                    disable_pulse <= 1'b1;
                    armed_q       <= 1'b0;
                end else begin
                    armed_q <= (key_data == KEY_FIRST);
                end
            end
        end
    end
endmodule

// File: rtl/wdw_core.sv
// Escalation state machine and counters in the watchdog domain.
module wdw_core
    import wdw_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               RST_HOLD    = 16,
    parameter logic [CNT_W-1:0] DEF_TIMEOUT = 1000,
    parameter logic [CNT_W-1:0] DEF_OPEN    = 500,
    parameter logic [CNT_W-1:0] DEF_GRACE   = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_ev,
    input  logic             cfg_ev,
    input  logic             dis_ev,
    input  logic             ack_ev,
    input  logic             clr_ev,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic [CNT_W-1:0] cfg_open,
    input  logic [CNT_W-1:0] cfg_grace,
    output logic             nmi_o,
    output logic             rst_o,
    output logic             active_o,
    output logic             cause_o
);
    localparam int              HOLD_W    = $clog2(RST_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);

    wd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    logic [CNT_W-1:0]  timeout_q, open_q, grace_q;
    logic              nmi_q, cause_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hold_d  = hold_q;
        unique case (state_q)
            ST_RUN: begin
                if (dis_ev) begin
                    state_d = ST_OFF;
                end else if (kick_ev && cnt_q > open_q) begin
                    state_d = ST_GRACE;
                    cnt_d   = grace_q;
                end else if (kick_ev) begin
                    cnt_d = timeout_q;
                end else if (cnt_q == '0) begin
                    state_d = ST_GRACE;
                    cnt_d   = grace_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_GRACE: begin
                if (kick_ev) begin
                    state_d = ST_RUN;
                    cnt_d   = timeout_q;
                end else if (cnt_q == '0) begin
                    state_d = ST_RESET;
                    hold_d  = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RESET: begin
                if (hold_q == HOLD_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = timeout_q;
                end else begin
                    hold_d = hold_q + 1'b1;
                end
            end
            ST_OFF:   state_d = ST_OFF;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register, counters and live configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            cnt_q     <= DEF_TIMEOUT;
            hold_q    <= '0;
            timeout_q <= DEF_TIMEOUT;
            open_q    <= DEF_OPEN;
            grace_q   <= DEF_GRACE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hold_q  <= hold_d;
            if (cfg_ev) begin
                timeout_q <= cfg_timeout;
                open_q    <= cfg_open;
                grace_q   <= cfg_grace;
            end
        end
    end

    // latched outputs: set on transition, cleared only by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q   <= 1'b0;
            cause_q <= 1'b0;
        end else begin
            if (state_q != ST_GRACE && state_d == ST_GRACE) nmi_q <= 1'b1;
            else if (ack_ev)                                 nmi_q <= 1'b0;
            if (state_q == ST_GRACE && state_d == ST_RESET) cause_q <= 1'b1;
            else if (clr_ev)                                 cause_q <= 1'b0;
        end
    end

    assign nmi_o    = nmi_q;
    assign cause_o  = cause_q;
    assign rst_o    = (state_q == ST_RESET);
    assign active_o = (state_q != ST_OFF);
endmodule

// File: rtl/wdw_watchdog.sv
module wdw_watchdog
    import wdw_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               RST_HOLD    = 16,
    parameter logic [CNT_W-1:0] DEF_TIMEOUT = 1000,
    parameter logic [CNT_W-1:0] DEF_OPEN    = 500,
    parameter logic [CNT_W-1:0] DEF_GRACE   = 200,
    parameter int               KEY_W       = 16,
    parameter logic [KEY_W-1:0] KEY_FIRST   = 16'hC35A,
    parameter logic [KEY_W-1:0] KEY_SECOND  = 16'h3CA5
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             wd_clk,
    input  logic             wd_rst_n,
    input  logic             kick_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_timeout_i,
    input  logic [CNT_W-1:0] cfg_open_i,
    input  logic [CNT_W-1:0] cfg_grace_i,
    input  logic             key_we_i,
    input  logic [KEY_W-1:0] key_data_i,
    input  logic             nmi_ack_i,
    input  logic             cause_clr_i,
    output logic             nmi_req_o,
    output logic             wd_rst_o,
    output logic             active_o,
    output logic             cause_o
);
    logic [CNT_W-1:0] bus_timeout_q, bus_open_q, bus_grace_q;
    logic             dis_pulse;
    logic [EV_N-1:0]  src_ev, dst_ev;

    // bus-side configuration holding registers, read by the watchdog domain after the event arrives
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            bus_timeout_q <= DEF_TIMEOUT;
            bus_open_q    <= DEF_OPEN;
            bus_grace_q   <= DEF_GRACE;
        end else if (cfg_we_i) begin
            bus_timeout_q <= cfg_timeout_i;
            bus_open_q    <= cfg_open_i;
            bus_grace_q   <= cfg_grace_i;
        end
    end

    wdw_unlock #(
        .KEY_W     (KEY_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_unlock (
        .clk          (bus_clk),
        .rst_n        (bus_rst_n),
        .key_we       (key_we_i),
        .key_data     (key_data_i),
        .disable_pulse(dis_pulse)
    );

    always_comb begin
        src_ev          = '0;
        src_ev[EV_KICK] = kick_i;
        src_ev[EV_CFG]  = cfg_we_i;
        src_ev[EV_DIS]  = dis_pulse;
        src_ev[EV_ACK]  = nmi_ack_i;
        src_ev[EV_CLR]  = cause_clr_i;
    end

    wdw_pulse_xing #(.N(EV_N)) u_xing (
        .src_clk  (bus_clk),
        .src_rst_n(bus_rst_n),
        .src_pulse(src_ev),
        .dst_clk  (wd_clk),
        .dst_rst_n(wd_rst_n),
        .dst_pulse(dst_ev)
    );

    wdw_core #(
        .CNT_W      (CNT_W),
        .RST_HOLD   (RST_HOLD),
        .DEF_TIMEOUT(DEF_TIMEOUT),
        .DEF_OPEN   (DEF_OPEN),
        .DEF_GRACE  (DEF_GRACE)
    ) u_core (
        .clk        (wd_clk),
        .rst_n      (wd_rst_n),
        .kick_ev    (dst_ev[EV_KICK]),
        .cfg_ev     (dst_ev[EV_CFG]),
        .dis_ev     (dst_ev[EV_DIS]),
        .ack_ev     (dst_ev[EV_ACK]),
        .clr_ev     (dst_ev[EV_CLR]),
        .cfg_timeout(bus_timeout_q),
        .cfg_open   (bus_open_q),
        .cfg_grace  (bus_grace_q),
        .nmi_o      (nmi_req_o),
        .rst_o      (wd_rst_o),
        .active_o   (active_o),
        .cause_o    (cause_o)
    );
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker #(
    parameter int RST_HOLD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic nmi,
    input logic wrst,
    input logic active,
    input logic cause
);
    logic [15:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    high_cnt <= '0;
        else if (wrst) high_cnt <= high_cnt + 1'b1;
        else           high_cnt <= '0;
    end

    // R6: reset pulse width is exactly the hold time
    assert_rst_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrst) |-> (high_cnt == 16'(RST_HOLD)));

    // R6: the watchdog comes back enabled after its own reset
    assert_active_after_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrst) |-> active);

    // R7: cause flag is present when the reset line rises
    assert_cause_on_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrst) |-> cause);

    // R4: interrupt stage never coincides with the reset line
    assert_nmi_before_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> !wrst);

    // R10: once off, stays off and quiet
    assert_off_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active);

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !wrst);
endmodule

bind wdw_watchdog wdw_checker #(.RST_HOLD(RST_HOLD)) u_wdw_checker (
    .clk   (wd_clk),
    .rst_n (wd_rst_n),
    .nmi   (nmi_req_o),
    .wrst  (wd_rst_o),
    .active(active_o),
    .cause (cause_o)
);

// File: tb/test_wdw_watchdog.sv
module test_wdw_watchdog;
    localparam int               CW   = 8;
    localparam int               KW   = 16;
    localparam int               HOLD = 16;
    localparam logic [KW-1:0]    K0   = 16'hC35A;
    localparam logic [KW-1:0]    K1   = 16'h3CA5;

    typedef struct packed {
        logic [7:0] delay;    // watchdog cycles from reset release to kick
        logic       exp_nmi;  // interrupt expected afterwards
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{delay: 8'd2,  exp_nmi: 1'b1},   // early, R3
        '{delay: 8'd8,  exp_nmi: 1'b1},   // early, R3
        '{delay: 8'd20, exp_nmi: 1'b0},   // in window, R3
        '{delay: 8'd30, exp_nmi: 1'b0},   // late in window, R2
        '{delay: 8'd50, exp_nmi: 1'b1}    // timed out then recovered, R5
    };

    logic wd_clk = 1'b0, bus_clk = 1'b0;
    logic wd_rst_n = 1'b0, bus_rst_n = 1'b0;
    logic kick = 1'b0, cfg_we = 1'b0, key_we = 1'b0, ack = 1'b0, clr = 1'b0;
    logic [CW-1:0] cfg_t = '0, cfg_o = '0, cfg_g = '0;
    logic [KW-1:0] key_d = '0;
    logic nmi, wrst, active, cause;
    int   n_run = 0, n_fail = 0;

    always #2 wd_clk = ~wd_clk;                 // 250 MHz
    initial begin
        #5;
        forever begin bus_clk = 1'b1; #5; bus_clk = 1'b0; #5; end
    end

    wdw_watchdog #(
        .CNT_W(CW), .RST_HOLD(HOLD),
        .DEF_TIMEOUT(8'd40), .DEF_OPEN(8'd20), .DEF_GRACE(8'd30),
        .KEY_W(KW), .KEY_FIRST(K0), .KEY_SECOND(K1)
    ) i_wdw_watchdog (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
        .kick_i(kick), .cfg_we_i(cfg_we), .cfg_timeout_i(cfg_t), .cfg_open_i(cfg_o),
        .cfg_grace_i(cfg_g), .key_we_i(key_we), .key_data_i(key_d),
        .nmi_ack_i(ack), .cause_clr_i(clr),
        .nmi_req_o(nmi), .wd_rst_o(wrst), .active_o(active), .cause_o(cause)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge wd_clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    task automatic check(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wait_wd(int n);
        repeat (n) @(negedge wd_clk);
    endtask

    task automatic do_reset();
        @(negedge wd_clk);
        wd_rst_n = 1'b0; bus_rst_n = 1'b0;
        wait_wd(4);
        wd_rst_n = 1'b1; bus_rst_n = 1'b1;
    endtask

    // 0 kick, 1 ack, 2 clear
    task automatic bus_pulse(int which);
        @(posedge bus_clk); #1;
        case (which)
            0: kick = 1'b1;
            1: ack  = 1'b1;
            default: clr = 1'b1;
        endcase
        @(posedge bus_clk); #1;
        kick = 1'b0; ack = 1'b0; clr = 1'b0;
    endtask

    task automatic key_write(logic [KW-1:0] v);
        @(posedge bus_clk); #1; key_we = 1'b1; key_d = v;
        @(posedge bus_clk); #1; key_we = 1'b0;
    endtask

    task automatic cfg_write(logic [CW-1:0] t, logic [CW-1:0] o, logic [CW-1:0] g);
        @(posedge bus_clk); #1; cfg_we = 1'b1; cfg_t = t; cfg_o = o; cfg_g = g;
        @(posedge bus_clk); #1; cfg_we = 1'b0;
    endtask

    initial begin
        int hi;
        bit gone;

        // R1: reset state
        do_reset();
        wait_wd(1);
        check("R1", "nmi after reset", nmi, 1'b0);
        check("R1", "rst after reset", wrst, 1'b0);
        check("R1", "active after reset", active, 1'b1);
        check("R1", "cause after reset", cause, 1'b0);

        // table: kick timing against the window
        for (int v = 0; v < 5; v++) begin
            do_reset();
            wait_wd(int'(VECS[v].delay));
            bus_pulse(0);
            wait_wd(10);
            check("R3", $sformatf("vector %0d nmi", v), nmi, VECS[v].exp_nmi);
            check("R5", $sformatf("vector %0d no reset", v), wrst, 1'b0);
        end

        // R2/R4/R6/R7/R8: full escalation with no kick
        do_reset();
        wait_wd(35);
        check("R2", "no fault before timeout", nmi, 1'b0);
        wait_wd(10);
        check("R2", "fault at timeout", nmi, 1'b1);
        check("R4", "no reset in nmi stage", wrst, 1'b0);
        wait_wd(23);
        check("R4", "grace still running", wrst, 1'b0);
        for (int i = 0; i < 20 && !wrst; i++) wait_wd(1);
        check("R6", "reset asserted after grace", wrst, 1'b1);
        hi = 0;
        for (int i = 0; i < 40 && wrst; i++) begin hi++; wait_wd(1); end
        n_run++;
        if (hi != HOLD) begin
            n_fail++;
            $display("FAIL R6 reset width: got %0d expected %0d", hi, HOLD);
        end
        check("R6", "enabled after own reset", active, 1'b1);
        check("R7", "cause kept across own reset", cause, 1'b1);
        check("R8", "nmi kept across reset", nmi, 1'b1);
        bus_pulse(1);
        wait_wd(8);
        check("R8", "nmi cleared by ack", nmi, 1'b0);
        check("R7", "cause not cleared by ack", cause, 1'b1);
        bus_pulse(2);
        wait_wd(8);
        check("R7", "cause cleared", cause, 1'b0);
        wait_wd(25);
        check("R6", "faults again after restart", nmi, 1'b1);

        // R5: recovery during grace
        do_reset();
        wait_wd(45);
        bus_pulse(0);
        gone = 1'b0;
        for (int i = 0; i < 40; i++) begin
            wait_wd(1);
            if (wrst) gone = 1'b1;
        end
        check("R5", "kick in grace cancels reset", gone, 1'b0);
        check("R8", "nmi latched after recovery", nmi, 1'b1);

        // R9: new timeout and grace
        do_reset();
        wait_wd(15);
        cfg_write(8'd80, 8'd30, 8'd10);
        bus_pulse(0);
        wait_wd(60);
        check("R9", "old timeout no longer fires", nmi, 1'b0);
        wait_wd(28);
        check("R9", "new timeout fires", nmi, 1'b1);
        wait_wd(12);
        check("R9", "short grace gives early reset", wrst, 1'b1);

        // R10: correct unlock
        do_reset();
        wait_wd(5);
        key_write(K0);
        key_write(K1);
        wait_wd(10);
        check("R10", "disabled by key pair", active, 1'b0);
        wait_wd(100);
        check("R10", "no nmi when off", nmi, 1'b0);
        check("R10", "no reset when off", wrst, 1'b0);

        // R10: broken sequence
        do_reset();
        wait_wd(5);
        key_write(K0);
        key_write(16'h1234);
        key_write(K1);
        wait_wd(10);
        check("R10", "interrupted sequence ignored", active, 1'b1);

        do_reset();
        wait_wd(5);
        key_write(K1);
        wait_wd(10);
        check("R10", "second key alone ignored", active, 1'b1);

        // R11: unlock during grace ignored
        do_reset();
        wait_wd(45);
        key_write(K0);
        key_write(K1);
        wait_wd(26);
        check("R11", "still active", active, 1'b1);
        check("R11", "reset still issued", wrst, 1'b1);

        finish_run();
    end
endmodule